// File: doc/BRIEF.md
# Register-Mapped Two-Wire Bias DAC Writer

This block sends a three-byte write to a bias DAC over a two-wire serial link. The link has no dedicated wires. It is carried on two bits of a power-control register. Every change of the clock or data line becomes one whole write to that register. The other bits of each write come from a base pattern, so the rest of the power state stays as it was.

A single-cycle strobe starts a transaction. The strobe carries a data byte and the base pattern. The block then emits the full sequence on a valid/ready write port:

- a start condition;
- a fixed command byte;
- a fixed second byte;
- the data byte;
- a stop condition.

Each byte is followed by an acknowledge slot. The acknowledge is never read. After each write is accepted, the block waits a fixed settle time before the next line change. That settle time is set in system clocks from the clock frequency and a time in nanoseconds.

Top module: `dac_wire_sender`

## Requirements
- R1: After reset, busy_o and wr_valid_o are low.
- R2: A start_i pulse while idle does the following:
  - It captures data_i and base_i.
  - From the next cycle it raises busy_o and presents the first write.
  - busy_o stays high until the final stop write has been accepted and its settle time has elapsed.
- R3: start_i while busy_o is high is ignored. The running transaction is unchanged, and no second transaction follows it.
- R4: Every write goes to address 3. Its value is the captured base pattern ORed with the clock line at bit 0 and the data line at bit 1.
- R5: A transaction opens with three writes whose (clock, data) values are (1,1), (1,0), (0,0).
- R6: Each bit takes three writes: (0,d), (1,d), (0,d). The bits of a byte go out most significant first.
- R7: After each byte comes one acknowledge slot. It is a bit cycle with data 0. No input is sampled, and the transfer always continues.
- R8: The byte order is 0x9C, then 0x00, then the captured data byte, for 87 writes in total.
- R9: A transaction closes with three writes: (0,0), (1,0), (1,1).
- R10: A write request whose wr_ready_i is low keeps wr_valid_o, the address and the value unchanged until it is accepted.
- R11: Exactly SETTLE_CYC cycles with wr_valid_o low lie between the cycle that accepts a write and the next request. SETTLE_CYC is CLK_MHZ*SETTLE_NS/1000, and at least 1.
- R12: Changes to data_i or base_i after the strobe have no effect on the running transaction.
- R13: Between consecutive writes at most one of the two lines changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction strobe |
| data_i | input | 8 | Byte to send to the DAC |
| base_i | input | REG_W | Pattern for the register's other bits |
| busy_o | output | 1 | Transaction in progress |
| wr_valid_o | output | 1 | Register write request |
| wr_ready_i | input | 1 | Downstream accepts the request |
| wr_addr_o | output | ADDR_W | Register address of the request |
| wr_data_o | output | REG_W | Register value of the request |

## Verification
A strobe is applied before a rising edge. busy_o and the first request are then due one cycle later, so the bench samples them at the following falling edge.

After each acceptance edge the bench counts falling edges with wr_valid_o low, and expects exactly SETTLE_CYC of them before the next request. After the last acceptance it expects busy_o to stay high for exactly SETTLE_CYC falling edges.

Each request is compared to the model on its first visible cycle. It is then compared for stability on every stalled cycle. wr_ready_i is only changed at falling edges, so each acceptance edge is known in advance.

// File: rtl/dac_wire_sender.sv
module dac_wire_sender #(
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 3,
  parameter int CLK_BIT  = 0,
  parameter int DAT_BIT  = 1,
  parameter int CLK_MHZ  = 250,
  parameter int SETTLE_NS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        data_i,
  input  logic [REG_W-1:0]  base_i,
  output logic              busy_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REG_W-1:0]  wr_data_o
);
  localparam int SETTLE_RAW = CLK_MHZ * SETTLE_NS / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int CW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [3:0]       bk;
  logic [1:0]       grp;
  logic             settling;
  logic [CW-1:0]    cnt;
  logic [7:0]       dat_q;
  logic [REG_W-1:0] base_q;
  logic [7:0]       cur_byte;
  logic             scl, sda;

  assign busy_o     = (st != S_IDLE);
  assign wr_valid_o = busy_o && !settling;
  assign wr_addr_o  = ADDR_W'(REG_ADDR);
  assign cur_byte   = (grp == 2'd0) ? 8'h9C : (grp == 2'd1) ? 8'h00 : dat_q;

  always_comb begin
    scl = 1'b1;
    sda = 1'b1;
    case (st)
      S_START: begin scl = (ph != 2'd2); sda = (ph == 2'd0); end
      S_BITS:  begin
        scl = (ph == 2'd1);
        sda = (bk == 4'd8) ? 1'b0 : cur_byte[3'd7 - bk[2:0]];
      end
      S_STOP:  begin scl = (ph != 2'd0); sda = (ph == 2'd2); end
      default: ;
    endcase
  end

  assign wr_data_o = base_q | (REG_W'(scl) << CLK_BIT) | (REG_W'(sda) << DAT_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      bk       <= '0;
      grp      <= '0;
      settling <= 1'b0;
      cnt      <= '0;
      dat_q    <= '0;
      base_q   <= '0;
    end else if (st == S_IDLE) begin
      if (start_i) begin
        st     <= S_START;
        ph     <= '0;
        bk     <= '0;
        grp    <= '0;
        dat_q  <= data_i;
        base_q <= base_i;
      end
    end else if (!settling) begin
      if (wr_ready_i) begin
        settling <= 1'b1;
        cnt      <= CW'(SETTLE_CYC - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      settling <= 1'b0;
      if (ph != 2'd2) begin
        ph <= ph + 1'b1;
      end else begin
        ph <= '0;
        case (st)
          S_START: begin st <= S_BITS; bk <= '0; grp <= '0; end
          S_BITS: begin
            if (bk != 4'd8) bk <= bk + 1'b1;
            else begin
              bk <= '0;
              if (grp == 2'd2) st <= S_STOP;
              else grp <= grp + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module dac_wire_sender_chk #(
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int REG_ADDR   = 3,
  parameter int CLK_BIT    = 0,
  parameter int DAT_BIT    = 1,
  parameter int SETTLE_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [REG_W-1:0]  base_i,
  input logic              busy_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [REG_W-1:0]  wr_data_o
);
  localparam int GW = $clog2(SETTLE_CYC + 2) + 1;
  localparam logic [REG_W-1:0] LMASK = (REG_W'(1) << CLK_BIT) | (REG_W'(1) << DAT_BIT);

  logic [GW-1:0]    gap;
  logic             acc_seen;
  logic [REG_W-1:0] base_cap;
  logic [1:0]       prev_lines;
  logic [1:0]       cur_lines;

  assign cur_lines = {wr_data_o[CLK_BIT], wr_data_o[DAT_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap        <= '0;
      acc_seen   <= 1'b0;
      base_cap   <= '0;
      prev_lines <= 2'b11;
    end else begin
      if (start_i && !busy_o) base_cap <= base_i;
      if (wr_valid_o && wr_ready_i) begin
        gap        <= '0;
        acc_seen   <= 1'b1;
        prev_lines <= cur_lines;
      end else if (!wr_valid_o && gap != {GW{1'b1}}) begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_valid_o); // R2
  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_addr_o == ADDR_W'(REG_ADDR)); // R4
  AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_data_o & ~LMASK) == (base_cap & ~LMASK)); // R12
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o))); // R10
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_valid_o) && acc_seen) |-> gap >= GW'(SETTLE_CYC)); // R11
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $countones(cur_lines ^ prev_lines) <= 1); // R13
endmodule

bind dac_wire_sender dac_wire_sender_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
  .CLK_BIT(CLK_BIT), .DAT_BIT(DAT_BIT), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
  .busy_o(busy_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
);

// File: tb/dac_wire_sender_tb.sv
module dac_wire_sender_tb;
  localparam int S = 10;
  localparam int NW = 87;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] base_i = '0;
  logic       busy_o, wr_valid_o;
  logic       wr_ready_i = 1'b0;
  logic [7:0] wr_addr_o, wr_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dac_wire_sender #(.CLK_MHZ(250), .SETTLE_NS(40)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i), .base_i(base_i),
    .busy_o(busy_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_lines(input int i, input logic [7:0] d);
    int b, p, g, k;
    logic [7:0] by;
    if (i < 3) return (i == 0) ? 2'b11 : (i == 1) ? 2'b10 : 2'b00;
    if (i >= 84) return (i == 84) ? 2'b00 : (i == 85) ? 2'b10 : 2'b11;
    b = (i - 3) / 3; p = (i - 3) % 3; g = b / 9; k = b % 9;
    by = (g == 0) ? 8'h9C : (g == 1) ? 8'h00 : d;
    return {p == 1, (k == 8) ? 1'b0 : by[7 - k]};
  endfunction

  function automatic string req_of(input int i);
    if (i < 3) return "R5";
    if (i >= 84) return "R9";
    if (((i - 3) / 3) % 9 == 8) return "R7";
    return "R6/R8";
  endfunction

  task automatic run_txn(input logic [7:0] d, input logic [7:0] b, input int stall, input bit poke);
    int idx = 0, gap = 0, hold = 0, cnt = 0;
    bit seen = 0;
    logic [7:0] held = '0;
    logic [1:0] prev = 2'b11, ln;
    logic [7:0] expv;
    @(negedge clk);
    start_i = 1; data_i = d; base_i = b;
    @(negedge clk);
    start_i = 0;
    check(busy_o === 1'b1 && wr_valid_o === 1'b1, "R2 busy and first write", {busy_o, wr_valid_o}, 2'b11);
    while (idx < NW) begin
      if (poke && idx >= 40 && idx < 43) begin start_i = 1; data_i = ~d; base_i = ~b & 8'hFC; end
      else start_i = 0;
      if (wr_valid_o) begin
        if (!seen) begin
          ln = exp_lines(idx, d);
          expv = b | {6'b0, ln[0], ln[1]};
          check(wr_addr_o == 8'd3, "R4 address", wr_addr_o, 3);
          check(wr_data_o == expv, req_of(idx), wr_data_o, expv);
          check($countones({wr_data_o[0], wr_data_o[1]} ^ prev) <= 1, "R13 one line", wr_data_o, prev);
          if (idx > 0) check(gap == S, "R11 settle gap", gap, S);
          prev = {wr_data_o[0], wr_data_o[1]};
          held = wr_data_o; seen = 1; hold = 0;
        end else begin
          check(wr_data_o == held, "R10 hold while stalled", wr_data_o, held);
        end
        wr_ready_i = (hold >= stall);
        hold++;
        if (wr_ready_i) begin idx++; seen = 0; gap = 0; end
      end else begin
        wr_ready_i = 0;
        gap++;
      end
      @(negedge clk);
    end
    wr_ready_i = 0; start_i = 0;
    while (busy_o && cnt < 1000) begin
      if (wr_valid_o) check(0, "R2 extra write", 1, 0);
      cnt++;
      @(negedge clk);
    end
    check(cnt == S, "R2 busy until last settle", cnt, S);
    cnt = 0;
    repeat (30) begin
      if (wr_valid_o || busy_o) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, poke ? "R3 strobe while busy ignored" : "R2 idle after txn", cnt, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && wr_valid_o === 1'b0, "R1 reset state", {busy_o, wr_valid_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy_o === 1'b0 && wr_valid_o === 1'b0, "R1 idle after reset", {busy_o, wr_valid_o}, 0);
  endtask

  task automatic t_plain();      run_txn(8'h7D, 8'h00, 0, 0); endtask
  task automatic t_base_stall(); run_txn(8'hA5, 8'hF4, 2, 0); endtask
  task automatic t_ignore();     run_txn(8'h00, 8'h18, 1, 1); endtask // R3 R12
  task automatic t_ones();       run_txn(8'hFF, 8'h1C, 0, 0); endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_base_stall();
    t_ignore();
    t_ones();
    report();
    $finish;
  end
endmodule